// File: doc/BRIEF.md
# Storage Channel Request Router

The router sits between a processor's execution unit and two storage-channel targets: a memory management unit (MMU) and an I/O unit. The execution unit presents one request per cycle: an instruction fetch, load, store, halfword test-and-set (an atomic modify), or an I/O register read or write. The router chooses the target and drives a shared request bus with a per-target strobe. One cycle later it turns that target's success flag into a response. A failed access becomes a program-check flag, and the flag says whether the fault was on an instruction address or on a data address.

Each request also carries a 3-bit access mode taken from the processor status word. A request marked unmasked, used when interrupt context is saved or restored, always carries mode zero. Read data is zero-extended by the router, and any sign extension is left to the requester. A new request may be issued in the same cycle that the previous one is answered.

Top module: `sc_router`

## Requirements
- R1: Load, store and modify requests whose address bits [31:28] equal 4'hF strobe only `iou_valid`. All other issued requests strobe only `mmu_valid`. At most one strobe is high in any cycle.
- R2: `bus_mode` equals status bits [11:9]. Mode bit 0 means translate, bit 1 means unprivileged and bit 2 means memory protect.
- R3: A request with `req_unmasked` high carries `bus_mode` = 0, whatever the status bits are.
- R4: An instruction fetch (op 0) always strobes the MMU, including at addresses whose top nibble is 4'hF. It is sent with `bus_size` = 1 (halfword), and its data returns zero-extended from 16 bits.
- R5: A fetch rejected by the target gives `chk_pc` and `chk_iae` with `rsp_ok` low. `chk_dae` stays low.
- R6: A load (op 1), store (op 2) or modify (op 3) rejected by either target gives `chk_pc` and `chk_dae`. On any failure `rsp_wb` is low and `rsp_rdata` is 0.
- R7: An I/O read (op 4) or I/O write (op 5) goes to the MMU as a word access. If address bits [31:24] are nonzero, or the op code is 6 or 7, no strobe is raised, and the response one cycle later fails with `chk_dae`.
- R8: Test-and-set (op 3) is sent as a halfword modify with `bus_wdata` = 32'h0000FF00, which is the OR mask the target applies atomically. The response returns the old halfword zero-extended, with `rsp_wb` high.
- R9: Every request gets exactly one response, with `rsp_valid` high in the following cycle. Byte (size 0) and halfword (size 1) load data is zero-extended. Size 2 and size 3 are word accesses. `rsp_wb` is high only for successful op 1, op 3 and op 4.
- R10: While reset is held and in the first cycle after it, `rsp_valid` and every check flag are low.
- R11: Back-to-back requests are handled with no idle cycle. The response to one request and the issue of the next request, to the same target or the other one, are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 fetch, 1 load, 2 store, 3 test-and-set, 4 I/O read, 5 I/O write |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Effective address |
| req_wdata | input | 32 | Store data, right-justified |
| req_unmasked | input | 1 | Force access mode 0 |
| status | input | 16 | Processor status word; bits [11:9] give the mode |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_ok | output | 1 | Access succeeded |
| rsp_wb | output | 1 | Destination register may be written |
| rsp_rdata | output | 32 | Zero-extended read data |
| chk_pc | output | 1 | Program check raised |
| chk_iae | output | 1 | Instruction address exception |
| chk_dae | output | 1 | Data address exception |
| mmu_valid | output | 1 | Strobe to the MMU |
| iou_valid | output | 1 | Strobe to the I/O unit |
| bus_op | output | 3 | Operation on the shared bus |
| bus_size | output | 2 | Access size on the bus |
| bus_mode | output | 3 | Access mode on the bus |
| bus_addr | output | 32 | Address on the bus |
| bus_wdata | output | 32 | Write data or OR mask |
| mmu_ok | input | 1 | MMU success, one cycle after its strobe |
| mmu_rdata | input | 32 | MMU read data, right-justified |
| iou_ok | input | 1 | I/O unit success, one cycle after its strobe |
| iou_rdata | input | 32 | I/O unit read data, right-justified |

## Verification
Two things can happen in the same cycle: a response is returned for request N, and request N+1 is issued on the shared bus. The bench runs back-to-back sequences in which N and N+1 go to the same target or to different targets, and in which one of them fails. A bus-level fault such as a rejected fetch is answered while a new data request is being issued. The reference model tracks its own copy of each target's storage. The bus fields are compared in every cycle, and so are the response and check flags. A misrouted request or a mixed-up pending state shows up as wrong data, a wrong flag or a wrong strobe.

// File: rtl/sc_router.sv
module sc_router #(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          SW        = 16,
  parameter int          MODE_LSB  = 9,
  parameter logic [3:0]  IO_NIBBLE = 4'hF,
  parameter logic [31:0] TAS_MASK  = 32'h0000_FF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_unmasked,
  input  logic [SW-1:0] status,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic          rsp_wb,
  output logic [DW-1:0] rsp_rdata,
  output logic          chk_pc,
  output logic          chk_iae,
  output logic          chk_dae,
  output logic          mmu_valid,
  output logic          iou_valid,
  output logic [2:0]    bus_op,
  output logic [1:0]    bus_size,
  output logic [2:0]    bus_mode,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          mmu_ok,
  input  logic [DW-1:0] mmu_rdata,
  input  logic          iou_ok,
  input  logic [DW-1:0] iou_rdata
);
  localparam logic [2:0] OP_FETCH = 3'd0, OP_LOAD = 3'd1, OP_STORE = 3'd2,
                         OP_TAS = 3'd3, OP_IOR = 3'd4, OP_IOW = 3'd5;
  localparam logic [1:0] SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2;

  logic is_data, is_io, io_bad, op_bad, to_iou, issue;
  logic p_valid, p_iou, p_skip;
  logic [2:0] p_op;
  logic [1:0] p_size;
  logic sel_ok, reads;
  logic [DW-1:0] sel_data, ext_data;

  assign is_data = (req_op == OP_LOAD) || (req_op == OP_STORE) || (req_op == OP_TAS);
  assign is_io   = (req_op == OP_IOR) || (req_op == OP_IOW);
  assign io_bad  = is_io && (|req_addr[AW-1:AW-8]);
  assign op_bad  = req_op > OP_IOW;
  assign to_iou  = is_data && (req_addr[AW-1:AW-4] == IO_NIBBLE);
  assign issue   = req_valid && !io_bad && !op_bad;

  assign mmu_valid = issue && !to_iou;
  assign iou_valid = issue && to_iou;
  assign bus_op    = req_op;
  assign bus_addr  = req_addr;
  assign bus_mode  = req_unmasked ? 3'd0 : status[MODE_LSB +: 3];
  assign bus_wdata = (req_op == OP_TAS) ? TAS_MASK : req_wdata;

  always_comb begin
    if (req_op == OP_FETCH || req_op == OP_TAS) bus_size = SZ_HALF;
    else if (is_io || req_size == 2'd3)         bus_size = SZ_WORD;
    else                                        bus_size = req_size;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      p_iou   <= 1'b0;
      p_skip  <= 1'b0;
      p_op    <= OP_FETCH;
      p_size  <= SZ_BYTE;
    end else begin
      p_valid <= req_valid;
      p_iou   <= to_iou;
      p_skip  <= io_bad || op_bad;
      p_op    <= req_op;
      p_size  <= bus_size;
    end
  end

  assign sel_ok   = !p_skip && (p_iou ? iou_ok : mmu_ok);
  assign sel_data = p_iou ? iou_rdata : mmu_rdata;
  assign reads    = (p_op == OP_FETCH) || (p_op == OP_LOAD) || (p_op == OP_TAS) || (p_op == OP_IOR);

  always_comb begin
    case (p_size)
      SZ_BYTE: ext_data = {{(DW-8){1'b0}}, sel_data[7:0]};
      SZ_HALF: ext_data = {{(DW-16){1'b0}}, sel_data[15:0]};
      default: ext_data = sel_data;
    endcase
  end

  assign rsp_valid = p_valid;
  assign rsp_ok    = p_valid && sel_ok;
  assign rsp_wb    = rsp_ok && (p_op == OP_LOAD || p_op == OP_TAS || p_op == OP_IOR);
  assign rsp_rdata = (rsp_ok && reads) ? ext_data : '0;
  assign chk_iae   = p_valid && !sel_ok && (p_op == OP_FETCH);
  assign chk_dae   = p_valid && !sel_ok && (p_op != OP_FETCH);
  assign chk_pc    = chk_iae || chk_dae;
endmodule

module sc_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  req_op,
  input logic [31:0] req_addr,
  input logic        req_unmasked,
  input logic        rsp_valid,
  input logic        rsp_ok,
  input logic        rsp_wb,
  input logic        chk_iae,
  input logic        chk_dae,
  input logic        mmu_valid,
  input logic        iou_valid,
  input logic [1:0]  bus_size,
  input logic [2:0]  bus_mode,
  input logic [31:0] bus_addr
);
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mmu_valid && iou_valid));
  p_iou_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    iou_valid |-> bus_addr[31:28] == 4'hF);
  p_unmasked_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_unmasked) |-> bus_mode == 3'd0);
  p_fetch_mmu_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd0) |-> (mmu_valid && !iou_valid && bus_size == 2'd1));
  p_iae_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_iae |-> (!chk_dae && !rsp_ok));
  p_fail_nowb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> !rsp_wb);
  p_badio_nostrobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 3'd4 || req_op == 3'd5) && req_addr[31:24] != 8'h00)
      |-> (!mmu_valid && !iou_valid));
  p_badio_dae_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 3'd4 || req_op == 3'd5) && req_addr[31:24] != 8'h00)
      |=> chk_dae);
  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

bind sc_router sc_router_chk u_sc_router_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .req_unmasked(req_unmasked), .rsp_valid(rsp_valid),
  .rsp_ok(rsp_ok), .rsp_wb(rsp_wb), .chk_iae(chk_iae), .chk_dae(chk_dae),
  .mmu_valid(mmu_valid), .iou_valid(iou_valid), .bus_size(bus_size),
  .bus_mode(bus_mode), .bus_addr(bus_addr)
);

// File: tb/sc_router_bench.sv
module sc_router_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_unmasked = 1'b0;
  logic [2:0] req_op = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [15:0] status = '0;
  logic rsp_valid, rsp_ok, rsp_wb, chk_pc, chk_iae, chk_dae, mmu_valid, iou_valid;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata;
  logic [2:0] bus_op, bus_mode;
  logic [1:0] bus_size;
  logic mmu_ok = 1'b0, iou_ok = 1'b0;
  logic [31:0] mmu_rdata = '0, iou_rdata = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sc_router u_sc_router (.*);

  logic [31:0] rm_m [16];
  logic [31:0] rm_i [16];
  logic [31:0] sh_m [16];
  logic [31:0] sh_i [16];

  always @(posedge clk) begin
    if (mmu_valid) begin
      mmu_ok    <= bus_addr[11:8] != 4'hB;
      mmu_rdata <= (bus_addr[11:8] != 4'hB) ? rm_m[bus_addr[5:2]] : 32'hDEAD_BEEF;
      if (bus_addr[11:8] != 4'hB) begin
        if (bus_op == 3'd2 || bus_op == 3'd5) rm_m[bus_addr[5:2]] <= bus_wdata;
        if (bus_op == 3'd3) rm_m[bus_addr[5:2]][15:0] <= rm_m[bus_addr[5:2]][15:0] | bus_wdata[15:0];
      end
    end else begin
      mmu_ok <= 1'b0; mmu_rdata <= 32'hDEAD_BEEF;
    end
    if (iou_valid) begin
      iou_ok    <= bus_addr[11:8] != 4'hB;
      iou_rdata <= (bus_addr[11:8] != 4'hB) ? rm_i[bus_addr[5:2]] : 32'hDEAD_BEEF;
      if (bus_addr[11:8] != 4'hB) begin
        if (bus_op == 3'd2 || bus_op == 3'd5) rm_i[bus_addr[5:2]] <= bus_wdata;
        if (bus_op == 3'd3) rm_i[bus_addr[5:2]][15:0] <= rm_i[bus_addr[5:2]][15:0] | bus_wdata[15:0];
      end
    end else begin
      iou_ok <= 1'b0; iou_rdata <= 32'hDEAD_BEEF;
    end
  end

  logic e_valid = 0, e_ok = 0, e_wb = 0, e_iae = 0, e_dae = 0;
  logic [31:0] e_data = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_rsp(input string tag);
    chk(tag, "rsp_valid R9", 32'(rsp_valid), 32'(e_valid));
    chk(tag, "rsp_ok R6", 32'(rsp_ok), 32'(e_ok));
    chk(tag, "rsp_wb R6", 32'(rsp_wb), 32'(e_wb));
    chk(tag, "rsp_rdata R9", rsp_rdata, e_data);
    chk(tag, "chk_iae R5", 32'(chk_iae), 32'(e_iae));
    chk(tag, "chk_dae R6", 32'(chk_dae), 32'(e_dae));
    chk(tag, "chk_pc R5", 32'(chk_pc), 32'(e_iae | e_dae));
  endtask

  task automatic step(input string tag, input logic v, input logic [2:0] op, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] wd, input logic um, input logic [2:0] md);
    logic io, bad, to_i, good, rd;
    logic [1:0] esz;
    logic [31:0] old;
    @(negedge clk);
    check_rsp(tag);
    req_valid = v; req_op = op; req_size = sz; req_addr = a; req_wdata = wd;
    req_unmasked = um; status = {4'b1010, md, 9'h0A5};
    io   = (op == 3'd4 || op == 3'd5);
    bad  = (io && a[31:24] != 8'h00) || op > 3'd5;
    to_i = (op >= 3'd1 && op <= 3'd3) && a[31:28] == 4'hF;
    esz  = (op == 3'd0 || op == 3'd3) ? 2'd1 : (io || sz == 2'd3) ? 2'd2 : sz;
    #1;
    chk(tag, "mmu_valid R1", 32'(mmu_valid), 32'(v && !bad && !to_i));
    chk(tag, "iou_valid R1", 32'(iou_valid), 32'(v && !bad && to_i));
    if (v && !bad) begin
      chk(tag, "bus_mode R2", 32'(bus_mode), um ? 32'd0 : 32'(md));
      chk(tag, "bus_size R4", 32'(bus_size), 32'(esz));
      chk(tag, "bus_wdata R8", bus_wdata, (op == 3'd3) ? 32'h0000_FF00 : wd);
      chk(tag, "bus_addr R1", bus_addr, a);
    end
    e_valid = v; e_ok = 0; e_wb = 0; e_data = 0; e_iae = 0; e_dae = 0;
    if (v) begin
      good = !bad && a[11:8] != 4'hB;
      old  = to_i ? sh_i[a[5:2]] : sh_m[a[5:2]];
      if (good) begin
        if (op == 3'd2 || op == 3'd5) begin
          if (to_i) sh_i[a[5:2]] = wd; else sh_m[a[5:2]] = wd;
        end
        if (op == 3'd3) begin
          if (to_i) sh_i[a[5:2]][15:0] = old[15:0] | 16'hFF00;
          else      sh_m[a[5:2]][15:0] = old[15:0] | 16'hFF00;
        end
      end
      rd = (op == 3'd0 || op == 3'd1 || op == 3'd3 || op == 3'd4);
      e_ok  = good;
      e_wb  = good && (op == 3'd1 || op == 3'd3 || op == 3'd4);
      e_iae = !good && op == 3'd0;
      e_dae = !good && op != 3'd0;
      if (good && rd)
        e_data = (esz == 2'd0) ? {24'h0, old[7:0]} : (esz == 2'd1) ? {16'h0, old[15:0]} : old;
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 3'd0, 2'd0, 32'h0, 32'h0, 1'b0, 3'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) begin
      rm_m[k] = '0; rm_i[k] = '0; sh_m[k] = '0; sh_i[k] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R10", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R10", "chk_pc in reset", 32'(chk_pc), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    idle("R10");
    // R2: mode per status, word store then loads of three sizes
    step("R2", 1, 3'd2, 2'd2, 32'h0000_0104, 32'h1234_5678, 0, 3'd5);
    step("R9", 1, 3'd1, 2'd2, 32'h0000_0104, 32'h0, 0, 3'd3);
    step("R9", 1, 3'd1, 2'd0, 32'h0000_0104, 32'h0, 0, 3'd6);
    step("R9", 1, 3'd1, 2'd1, 32'h0000_0104, 32'h0, 0, 3'd1);
    step("R9", 1, 3'd1, 2'd3, 32'h0000_0104, 32'h0, 0, 3'd0);
    // R1: I/O unit region
    step("R1", 1, 3'd2, 2'd2, 32'hF000_0108, 32'hCAFE_F00D, 0, 3'd2);
    step("R1", 1, 3'd1, 2'd2, 32'hF000_0108, 32'h0, 0, 3'd2);
    step("R1", 1, 3'd1, 2'd2, 32'hE000_0108, 32'h0, 0, 3'd2);
    // R3: unmasked forces mode 0
    step("R3", 1, 3'd2, 2'd2, 32'hF000_010C, 32'h0BAD_CAFE, 1, 3'd7);
    chk("R3", "bus_mode unmasked", 32'(bus_mode), 32'd0);
    step("R3", 1, 3'd1, 2'd2, 32'hF000_010C, 32'h0, 1, 3'd7);
    // R4: fetch always to MMU, halfword
    step("R4", 1, 3'd0, 2'd2, 32'hF000_0104, 32'h0, 0, 3'd4);
    chk("R4", "fetch to mmu", 32'(mmu_valid), 32'd1);
    step("R4", 1, 3'd0, 2'd0, 32'h0000_0104, 32'h0, 0, 3'd1);
    // R5: fetch fault, directly followed by a data request (R11)
    step("R5", 1, 3'd0, 2'd1, 32'h0000_0B00, 32'h0, 0, 3'd1);
    step("R11", 1, 3'd1, 2'd2, 32'hF000_0108, 32'h0, 0, 3'd1);
    // R6: data faults on both targets
    step("R6", 1, 3'd1, 2'd2, 32'hF000_0B04, 32'h0, 0, 3'd0);
    step("R6", 1, 3'd2, 2'd2, 32'h0000_0B04, 32'h1111_1111, 0, 3'd0);
    step("R6", 1, 3'd3, 2'd1, 32'h0000_0B10, 32'h0, 0, 3'd0);
    step("R6", 1, 3'd1, 2'd2, 32'h0000_0B04, 32'h0, 0, 3'd0);
    // R8: test-and-set twice, then read back
    step("R8", 1, 3'd2, 2'd2, 32'h0000_0120, 32'hAAAA_0034, 0, 3'd0);
    step("R8", 1, 3'd3, 2'd0, 32'h0000_0120, 32'h0, 0, 3'd0);
    step("R8", 1, 3'd3, 2'd2, 32'h0000_0120, 32'h0, 0, 3'd0);
    step("R8", 1, 3'd1, 2'd2, 32'h0000_0120, 32'h0, 0, 3'd0);
    step("R8", 1, 3'd3, 2'd1, 32'hF000_0124, 32'h0, 0, 3'd0);
    // R7: I/O instructions
    step("R7", 1, 3'd5, 2'd0, 32'h0000_0140, 32'h5566_7788, 0, 3'd0);
    step("R7", 1, 3'd4, 2'd0, 32'h0000_0140, 32'h0, 0, 3'd0);
    step("R7", 1, 3'd4, 2'd2, 32'h0100_0140, 32'h0, 0, 3'd0);
    chk("R7", "no strobe bad io", 32'(mmu_valid | iou_valid), 32'd0);
    step("R7", 1, 3'd5, 2'd2, 32'h8000_0140, 32'h1, 0, 3'd0);
    step("R7", 1, 3'd6, 2'd2, 32'h0000_0140, 32'h1, 0, 3'd0);
    step("R7", 1, 3'd7, 2'd2, 32'h0000_0140, 32'h1, 0, 3'd0);
    step("R7", 1, 3'd4, 2'd2, 32'h0000_0B40, 32'h0, 0, 3'd0);
    // R11: dense back-to-back mix across targets
    for (int i = 0; i < 120; i++) begin
      logic [31:0] a;
      logic [2:0] op;
      op = 3'((i * 5 + i / 7) % 6);
      a  = {((i % 3) == 0) ? 4'hF : 4'h0, 16'h0, ((i % 11) == 4) ? 4'hB : 4'h1, 2'b0, 4'(i * 3), 2'b0};
      if (op >= 3'd4) a[31:28] = ((i % 9) == 0) ? 4'h2 : 4'h0;
      step("R11", 1, op, 2'(i), a, 32'(i * 32'h0101_0107), 1'(i % 4 == 0), 3'(i));
    end
    idle("R11");
    idle("R9");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule